// File: doc/BRIEF.md
# Interrupt Priority Save Stack

This block keeps the running priority of an interrupt controller across nested preemptions. When a higher-priority request preempts the current handler, the controller pushes the old 4-bit priority. When that handler signals its end, the controller pops, and the saved value comes back as the new running priority. The store sits inside the controller and has no register access. The arbitration that decides when to push or pop is outside the block.

The store has 14 slots, but it covers 15 nesting levels. Level 15 is never preempted, so the deepest chain saves at most 15 values, and the oldest of these is always priority 0. A push into a full store drops its oldest entry. A pop from an empty store returns 0. Together these two rules recreate the one value that was dropped. Neither case raises a flag.

The pop data is combinational: it shows the top entry in the same cycle that the pop strobe is high, and it shows zero while the store is empty. The storage is a circular array addressed by a wrapping top pointer, with a saturating occupancy count beside it.

Top module: `prio_save_stack`

## Requirements
- R1: A synchronous active-high reset empties the store. Afterwards pop_pri_o reads 0 and every pop returns 0 until a push occurs.
- R2: While the store holds data, pop_pri_o shows the most recently saved value, already valid in the cycle the pop strobe is high.
- R3: Pops return the values in the reverse order of their pushes.
- R4: The store holds 14 entries. After 14 pushes, 14 pops return all 14 values, newest first, and a 15th pop returns 0.
- R5: A push into a full store discards the oldest entry and keeps the newest 14. The count stays at 14 and never exceeds 14.
- R6: A pop from an empty store returns 0 and leaves the store empty. A later push followed by a pop returns the pushed value.
- R7: When push and pop are high in the same cycle, pop_pri_o returns the current top value. The pushed value then replaces the top entry and the count does not change. If the store was empty, it stays empty.
- R8: In a cycle with neither strobe high, the contents and the count do not change.
- R9: A 15-deep nesting chain whose first saved value is 0, followed by 15 pops, restores all 15 values, ending with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Save strobe |
| push_pri_i | input | 4 | Priority to save |
| pop_i | input | 1 | Restore strobe |
| pop_pri_o | output | 4 | Top saved priority, 0 when empty |

## Verification
The push and pop sequence is tried with several patterns:
- **Shallow nesting with interleaved pops.** This separates last-in-first-out order from first-in-first-out order.
- **Exactly 14 pushes.** This shows that a full store loses nothing.
- **15 and 16 pushes.** These show that the oldest entry is the one dropped, and not the newest.
- **Combined push-and-pop cycles on an empty store and on a full store.** These separate replacing the top entry from a plain push or a plain pop.
- **Idle stretches.** These confirm that the state holds between strobes.
- **A zero-based 15-level chain.** This confirms that the empty-pop zero stands in for the dropped entry.

// File: rtl/prio_stack_pkg.sv
package prio_stack_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    case ({pop, push})
      2'b01:   decode_op = OP_PUSH;
      2'b10:   decode_op = OP_POP;
      2'b11:   decode_op = OP_SWAP;
      default: decode_op = OP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/prio_stack_ctrl.sv
module prio_stack_ctrl
  import prio_stack_pkg::*;
#(
  parameter int DEPTH = 14,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  stk_op_e          op,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PTR_W-1:0] top_idx,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] top_q, top_d, top_inc, top_dec;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    top_inc = (top_q == LAST) ? '0 : top_q + 1'b1;
    top_dec = (top_q == '0) ? LAST : top_q - 1'b1;
  end

  always_comb begin
    top_d   = top_q;
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    wr_addr = top_q;
    case (op)
      OP_PUSH: begin
        top_d   = top_inc;
        wr_en   = 1'b1;
        wr_addr = top_inc;
        cnt_d   = (cnt_q == FULL) ? FULL : cnt_q + 1'b1;
      end
      OP_POP: begin
        if (cnt_q != '0) begin
          top_d = top_dec;
          cnt_d = cnt_q - 1'b1;
        end
      end
      OP_SWAP: begin
        wr_en   = 1'b1;
        wr_addr = top_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= LAST;
      cnt_q <= '0;
    end else begin
      top_q <= top_d;
      cnt_q <= cnt_d;
    end
  end

  assign top_idx = top_q;
  assign cnt     = cnt_q;

  // R1
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_q == '0));

  // R5
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);

  // R5
  a_r5_full_sat: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL && op == OP_PUSH) |=> (cnt_q == FULL));

  // R6
  a_r6_empty_pop_stays: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && op == OP_POP) |=> (cnt_q == '0));

  // R7
  a_r7_swap_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SWAP) |=> (cnt_q == $past(cnt_q) && top_q == $past(top_q)));

  // R8
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE) |=> (cnt_q == $past(cnt_q) && top_q == $past(top_q)));

endmodule

// File: rtl/prio_stack_ram.sv
module prio_stack_ram #(
  parameter int DATA_W = 4,
  parameter int DEPTH  = 14,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  // R7: a write address must stay inside the array
  a_r7_addr_range: assert property (@(posedge clk)
    wr_en |-> (int'(wr_addr) < DEPTH));

endmodule

// File: rtl/prio_save_stack.sv
module prio_save_stack
  import prio_stack_pkg::*;
#(
  parameter int PRI_W = 4,
  parameter int DEPTH = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [PRI_W-1:0] push_pri_i,
  input  logic             pop_i,
  output logic [PRI_W-1:0] pop_pri_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  stk_op_e          op;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr;
  logic [PTR_W-1:0] top_idx;
  logic [CNT_W-1:0] cnt;
  logic [PRI_W-1:0] top_data;

  assign op = decode_op(push_i, pop_i);

  prio_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .top_idx (top_idx),
    .cnt     (cnt)
  );

  prio_stack_ram #(.DATA_W(PRI_W), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (push_pri_i),
    .rd_addr (top_idx),
    .rd_data (top_data)
  );

  always_comb begin
    pop_pri_o = (cnt == '0) ? '0 : top_data;
  end

  // R6: an empty store reads as priority zero
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> (pop_pri_o == '0));

  // R2: a plain push makes the pushed value the visible top
  a_r2_push_visible: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |=> (pop_pri_o == $past(push_pri_i)));

endmodule

// File: tb/tb_prio_save_stack.sv
`timescale 1ns/1ps
module tb_prio_save_stack;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_i = 1'b0;
  logic [3:0] push_pri_i = '0;
  logic       pop_i = 1'b0;
  logic [3:0] pop_pri_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_save_stack dut (
    .clk        (clk),
    .rst        (rst),
    .push_i     (push_i),
    .push_pri_i (push_pri_i),
    .pop_i      (pop_i),
    .pop_pri_o  (pop_pri_o)
  );

  // {push, pop, data[3:0], expected pop_pri_o during that cycle [3:0]}
  localparam logic [9:0] VEC [16] = '{
    {1'b0, 1'b1, 4'd0, 4'd0},  // R6 pop when empty
    {1'b1, 1'b0, 4'd3, 4'd0},  // R3 push 3
    {1'b1, 1'b0, 4'd7, 4'd3},  // R2 push 7, top is 3
    {1'b1, 1'b0, 4'd9, 4'd7},  // R2 push 9, top is 7
    {1'b0, 1'b0, 4'd0, 4'd9},  // R8 idle
    {1'b0, 1'b1, 4'd0, 4'd9},  // R3 pop 9
    {1'b0, 1'b1, 4'd0, 4'd7},  // R3 pop 7
    {1'b1, 1'b1, 4'd5, 4'd3},  // R7 replace 3 with 5
    {1'b0, 1'b1, 4'd0, 4'd5},  // R7 pop replaced value
    {1'b0, 1'b1, 4'd0, 4'd0},  // R6 empty again
    {1'b0, 1'b0, 4'd0, 4'd0},  // R8 idle empty
    {1'b1, 1'b1, 4'd6, 4'd0},  // R7 swap on empty
    {1'b0, 1'b0, 4'd0, 4'd0},  // R7 stays empty
    {1'b1, 1'b0, 4'd2, 4'd0},  // R6 push after empty pops
    {1'b0, 1'b1, 4'd0, 4'd2},  // R6 pop returns pushed value
    {1'b0, 1'b0, 4'd0, 4'd0}   // R3 drained
  };

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic q, input logic [3:0] d,
                      input logic [3:0] exp, input string req);
    @(negedge clk);
    push_i = p; pop_i = q; push_pri_i = d;
    #1;
    check(pop_pri_o, exp, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; push_i = 1'b0; pop_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    step(1'b0, 1'b0, 4'd0, 4'd0, "R1 reset output");

    for (int i = 0; i < 16; i++) begin
      step(VEC[i][9], VEC[i][8], VEC[i][7:4], VEC[i][3:0], "R3/R6/R7 table vector");
    end

    // R1: reset in the middle of use
    step(1'b1, 1'b0, 4'd5, 4'd0, "R1 push before reset");
    step(1'b1, 1'b0, 4'd6, 4'd5, "R1 push before reset");
    do_reset();
    step(1'b0, 1'b1, 4'd0, 4'd0, "R1 pop after reset");
    step(1'b0, 1'b0, 4'd0, 4'd0, "R1 stays empty");

    // R4: exactly full, nothing lost
    for (int k = 1; k <= 14; k++) step(1'b1, 1'b0, 4'(k), 4'(k - 1), "R4 fill");
    for (int k = 14; k >= 1; k--) step(1'b0, 1'b1, 4'd0, 4'(k), "R4 drain");
    step(1'b0, 1'b1, 4'd0, 4'd0, "R4 pop past depth");

    // R5: 16 pushes, newest 14 kept (values 3..15 then 0)
    for (int k = 1; k <= 16; k++) step(1'b1, 1'b0, 4'(k), 4'(k - 1), "R5 overfill");
    for (int k = 16; k >= 3; k--) step(1'b0, 1'b1, 4'd0, 4'(k), "R5 newest kept");
    step(1'b0, 1'b1, 4'd0, 4'd0, "R5 oldest discarded");
    step(1'b0, 1'b0, 4'd0, 4'd0, "R5 empty after drain");

    // R9: zero-based 15-level nesting
    step(1'b1, 1'b0, 4'd0, 4'd0, "R9 push base 0");
    for (int k = 1; k <= 14; k++) step(1'b1, 1'b0, 4'(k), 4'(k - 1), "R9 nest");
    for (int k = 14; k >= 1; k--) step(1'b0, 1'b1, 4'd0, 4'(k), "R9 unwind");
    step(1'b0, 1'b1, 4'd0, 4'd0, "R9 restored base 0");
    step(1'b0, 1'b1, 4'd0, 4'd0, "R9 extra pop");

    // R7: swap while full keeps count at 14
    for (int k = 1; k <= 14; k++) step(1'b1, 1'b0, 4'(k), 4'(k - 1), "R7 fill");
    step(1'b1, 1'b1, 4'd15, 4'd14, "R7 swap when full");
    step(1'b0, 1'b1, 4'd0, 4'd15, "R7 replaced top");
    for (int k = 13; k >= 1; k--) step(1'b0, 1'b1, 4'd0, 4'(k), "R7 rest intact");
    step(1'b0, 1'b1, 4'd0, 4'd0, "R7 count unchanged");

    // R8: idle hold
    step(1'b1, 1'b0, 4'd9, 4'd0, "R8 push");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 4'd3, 4'd9, "R8 idle hold");
    step(1'b0, 1'b1, 4'd0, 4'd9, "R8 pop after idle");
    step(1'b0, 1'b0, 4'd0, 4'd0, "R8 empty");

    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule